// File: doc/BRIEF.md
# Masked Wide Access Splitter

This block accepts one load or store request at a time, described by a start address, a length in bytes (1 up to a configurable maximum) and an optional per-byte enable mask. It cuts the access at line boundaries into fragments. Each fragment gets the part of the mask that covers its own bytes. A fragment whose bytes are all disabled is dropped. The address bookkeeping still steps past a dropped fragment, so every later fragment keeps its true address.

The surviving fragments leave in ascending address order on a valid/ready port. Each fragment carries its address, its length and its mask slice. The block counts the fragment responses. When the count reaches the number of surviving fragments, it pulses a completion strobe and becomes ready for the next access.

An access with no enabled byte issues nothing. It completes in the cycle after it is accepted, and a suppressed flag is raised with the completion strobe.

Top module: `wide_access_splitter`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `frag_valid`, `done` and `done_suppressed` are 0.
- R2: A request is taken only while `req_ready` is 1. `req_ready` stays 0 from acceptance until the completion cycle, and a request offered while busy has no effect on the fragments issued.
- R3: Fragments are cut at boundaries of `LINE_BYTES`. Let offset be the address modulo `LINE_BYTES`. The first fragment is the smaller of the request length and (`LINE_BYTES` minus offset). Middle fragments are one full line. The last fragment holds what remains. Fragments go out in ascending address order, and each `frag_size` is between 1 and `LINE_BYTES`.
- R4: Bit k of `frag_mask` enables byte `frag_addr`+k, so the slice is packed at bit 0. Bits at or above `frag_size` are 0. When `req_mask_en` is 0, every requested byte is enabled. Bits of `req_mask` at positions at or above `req_size` are ignored.
- R5: A fragment whose slice is all zero is never issued, and the fragments after it keep their own line-based addresses.
- R6: `frag_last` is 1 exactly on the final surviving fragment of an access.
- R7: While `frag_valid` is 1 and `frag_ready` is 0, the fragment address, size, mask and last flag hold steady.
- R8: `done` pulses for one cycle once the number of `rsp_valid` cycles counted since acceptance equals the number of surviving fragments. For such an access `done_suppressed` is 0, and `done` is never 1 together with `frag_valid`.
- R9: An access with no enabled byte issues no fragment. Its `done` and `done_suppressed` are both 1 in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_is_load | input | 1 | 1 for load, 0 for store |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | $clog2(MAX_BYTES+1) | Length in bytes, 1..MAX_BYTES |
| req_mask_en | input | 1 | 1 when `req_mask` applies, 0 when all bytes are enabled |
| req_mask | input | MAX_BYTES | Bit k enables byte k of the access |
| frag_valid | output | 1 | Fragment available |
| frag_ready | input | 1 | Downstream takes the fragment |
| frag_is_load | output | 1 | Direction of the access |
| frag_addr | output | ADDR_W | Fragment start address |
| frag_size | output | $clog2(LINE_BYTES+1) | Fragment length in bytes |
| frag_mask | output | LINE_BYTES | Fragment byte enables, bit 0 = first byte |
| frag_last | output | 1 | Final surviving fragment |
| rsp_valid | input | 1 | One fragment response retired |
| done | output | 1 | Access complete (one-cycle pulse) |
| done_suppressed | output | 1 | With `done`: the access made no memory request |

## Verification
A wrong set of issued-fragment flags shows at the port within one handshake. It appears as a repeated or skipped fragment address, a `frag_last` on the wrong fragment, or a stream that never ends. A wrong retire count shows as `done` arriving before the last response or never arriving, and the per-access fragment and response tallies catch this at the completion cycle. A bad surviving-fragment computation appears at once for a fully masked access: the completion strobe is missing from the first cycle after acceptance, or the suppressed flag is missing. Stalled cycles and requests offered while busy expose any state that moves when it should hold.

// File: rtl/was_pkg.sv
package was_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } was_state_e;
endpackage

// File: rtl/was_frag_slot.sv
// Geometry of one line-sized slot of an access: relative start, length,
// mask slice (packed at bit 0) and whether it carries any enabled byte.
module was_frag_slot #(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned MAX_BYTES  = 64,
  parameter int unsigned SLOT       = 0,
  parameter int unsigned REL_W      = 7,
  localparam int unsigned LB_W  = $clog2(LINE_BYTES),
  localparam int unsigned SZ_W  = $clog2(MAX_BYTES + 1),
  localparam int unsigned LEN_W = $clog2(LINE_BYTES + 1)
) (
  input  logic [LB_W-1:0]       offset,
  input  logic [SZ_W-1:0]       size,
  input  logic [MAX_BYTES-1:0]  mask,
  output logic [REL_W-1:0]      rel_start,
  output logic [LEN_W-1:0]      len,
  output logic [LINE_BYTES-1:0] slice,
  output logic                  alive
);
  logic [REL_W-1:0] off_ext, sz_ext, line_end, rel_end;
  logic             exists;
  logic [MAX_BYTES+LINE_BYTES-1:0] shifted;

  always_comb begin
    off_ext  = REL_W'(offset);
    sz_ext   = REL_W'(size);
    if (SLOT == 0) rel_start = '0;
    else           rel_start = REL_W'(SLOT * LINE_BYTES) - off_ext;
    line_end = REL_W'((SLOT + 1) * LINE_BYTES) - off_ext;
    rel_end  = (line_end < sz_ext) ? line_end : sz_ext;
    exists   = rel_start < sz_ext;
    len      = exists ? LEN_W'(rel_end - rel_start) : '0;
    shifted  = {{LINE_BYTES{1'b0}}, mask} >> rel_start;
    for (int b = 0; b < LINE_BYTES; b++) begin
      slice[b] = shifted[b] & (LEN_W'(b) < len);
    end
    alive = exists & (|slice);
  end
endmodule

// File: rtl/was_pick_lowest.sv
// Index of the lowest set bit of a request vector.
module was_pick_lowest #(
  parameter int unsigned N = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/wide_access_splitter.sv
module wide_access_splitter #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned MAX_BYTES  = 64,
  localparam int unsigned LB_W   = $clog2(LINE_BYTES),
  localparam int unsigned SZ_W   = $clog2(MAX_BYTES + 1),
  localparam int unsigned LEN_W  = $clog2(LINE_BYTES + 1),
  localparam int unsigned NFRAG  = (MAX_BYTES + 2 * LINE_BYTES - 2) / LINE_BYTES,
  localparam int unsigned REL_W  = $clog2(NFRAG * LINE_BYTES + 1),
  localparam int unsigned CNT_W  = $clog2(NFRAG + 1),
  localparam int unsigned IDX_W  = (NFRAG > 1) ? $clog2(NFRAG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_is_load,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [SZ_W-1:0]       req_size,
  input  logic                  req_mask_en,
  input  logic [MAX_BYTES-1:0]  req_mask,
  output logic                  frag_valid,
  input  logic                  frag_ready,
  output logic                  frag_is_load,
  output logic [ADDR_W-1:0]     frag_addr,
  output logic [LEN_W-1:0]      frag_size,
  output logic [LINE_BYTES-1:0] frag_mask,
  output logic                  frag_last,
  input  logic                  rsp_valid,
  output logic                  done,
  output logic                  done_suppressed
);
  import was_pkg::*;

  // registered access
  was_state_e           st_q, st_d;
  logic [ADDR_W-1:0]    base_q;
  logic [SZ_W-1:0]      size_q;
  logic [MAX_BYTES-1:0] mask_q, eff_mask;
  logic                 load_q;
  logic [NFRAG-1:0]     sent_q, sent_d;
  logic [CNT_W-1:0]     ret_q, ret_d;

  // slot geometry
  logic [REL_W-1:0]      slot_rel   [NFRAG];
  logic [LEN_W-1:0]      slot_len   [NFRAG];
  logic [LINE_BYTES-1:0] slot_slice [NFRAG];
  logic [NFRAG-1:0]      slot_alive;

  logic [NFRAG-1:0] remaining;
  logic [IDX_W-1:0] sel;
  logic             any_left;
  logic [CNT_W-1:0] surv_cnt;
  logic             running, accept, fire, cap_en, trk_en;

  for (genvar g = 0; g < NFRAG; g++) begin : g_slot
    was_frag_slot #(
      .LINE_BYTES (LINE_BYTES),
      .MAX_BYTES  (MAX_BYTES),
      .SLOT       (g),
      .REL_W      (REL_W)
    ) u_slot (
      .offset    (base_q[LB_W-1:0]),
      .size      (size_q),
      .mask      (mask_q),
      .rel_start (slot_rel[g]),
      .len       (slot_len[g]),
      .slice     (slot_slice[g]),
      .alive     (slot_alive[g])
    );
  end

  was_pick_lowest #(.N(NFRAG)) u_pick (
    .req (remaining),
    .idx (sel),
    .any (any_left)
  );

  // effective mask at capture: absent mask enables all, beyond-size bytes off
  always_comb begin
    for (int b = 0; b < MAX_BYTES; b++) begin
      eff_mask[b] = (req_mask[b] | ~req_mask_en) & (SZ_W'(b) < req_size);
    end
  end

  // control, next-state
  always_comb begin
    running   = (st_q == ST_RUN);
    req_ready = ~running;
    accept    = req_valid & ~running;
    remaining = running ? (slot_alive & ~sent_q) : '0;
    surv_cnt  = CNT_W'($countones(slot_alive));
    frag_valid = running & any_left;
    fire      = frag_valid & frag_ready;
    done      = running & (ret_q == surv_cnt);
    done_suppressed = done & (surv_cnt == '0);

    frag_is_load = load_q;
    frag_addr    = base_q + ADDR_W'(slot_rel[sel]);
    frag_size    = slot_len[sel];
    frag_mask    = slot_slice[sel];
    frag_last    = ($countones(remaining) == 1);

    cap_en = accept;
    trk_en = accept | running;
    st_d   = st_q;
    sent_d = sent_q;
    ret_d  = ret_q;
    if (accept) begin
      st_d   = ST_RUN;
      sent_d = '0;
      ret_d  = '0;
    end else if (running) begin
      if (done) st_d = ST_IDLE;
      if (fire) sent_d[sel] = 1'b1;
      if (rsp_valid && !done) ret_d = ret_q + CNT_W'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      mask_q <= '0;
      load_q <= 1'b0;
    end else if (cap_en) begin
      base_q <= req_addr;
      size_q <= req_size;
      mask_q <= eff_mask;
      load_q <= req_is_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sent_q <= '0;
      ret_q  <= '0;
    end else if (trk_en) begin
      st_q   <= st_d;
      sent_q <= sent_d;
      ret_q  <= ret_d;
    end
  end
endmodule

// File: rtl/wide_access_splitter_chk.sv
module wide_access_splitter_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned LEN_W = $clog2(LINE_BYTES + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  frag_valid,
  input logic                  frag_ready,
  input logic [ADDR_W-1:0]     frag_addr,
  input logic [LEN_W-1:0]      frag_size,
  input logic [LINE_BYTES-1:0] frag_mask,
  input logic                  frag_last,
  input logic                  done,
  input logic                  done_suppressed
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (req_valid && req_ready) begin
      have_prev <= 1'b0;
    end else if (frag_valid && frag_ready) begin
      have_prev <= 1'b1;
      prev_addr <= frag_addr;
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!frag_valid && !done));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && have_prev) |-> (frag_addr > prev_addr));

  a_r3_size_range: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (frag_size != '0 && frag_size <= LEN_W'(LINE_BYTES)));

  a_r5_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (frag_mask != '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_valid && !frag_ready) |=>
      (frag_valid && $stable(frag_addr) && $stable(frag_size)
       && $stable(frag_mask) && $stable(frag_last)));

  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !frag_valid);

  a_r9_sup_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done_suppressed |-> (done && $past(req_valid && req_ready)));
endmodule

bind wide_access_splitter wide_access_splitter_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .frag_valid      (frag_valid),
  .frag_ready      (frag_ready),
  .frag_addr       (frag_addr),
  .frag_size       (frag_size),
  .frag_mask       (frag_mask),
  .frag_last       (frag_last),
  .done            (done),
  .done_suppressed (done_suppressed)
);

// File: tb/test_wide_access_splitter.sv
module test_wide_access_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE   = 16;
  localparam int MAXB   = 64;

  typedef struct packed {
    logic [31:0] addr;
    logic [6:0]  size;
    logic        men;
    logic [63:0] mask;
    logic [3:0]  nfrag;
    logic        sup;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h100, 7'd4,  1'b0, 64'h0, 4'd1, 1'b0},
    '{32'h10C, 7'd8,  1'b0, 64'h0, 4'd2, 1'b0},
    '{32'h203, 7'd64, 1'b0, 64'h0, 4'd5, 1'b0},
    '{32'h203, 7'd64, 1'b1, 64'hFFFF_FFFF_FFFF_E000, 4'd4, 1'b0},
    '{32'h203, 7'd64, 1'b1, 64'h8000_0000_0000_0000, 4'd1, 1'b0},
    '{32'h10C, 7'd8,  1'b1, 64'h0, 4'd0, 1'b1},
    '{32'h100, 7'd4,  1'b1, 64'h0, 4'd0, 1'b1},
    '{32'h300, 7'd48, 1'b1, 64'h0000_FFFF_0000_FFFF, 4'd2, 1'b0},
    '{32'h3F0, 7'd16, 1'b0, 64'h0, 4'd1, 1'b0},
    '{32'h400, 7'd4,  1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 4'd0, 1'b1},
    '{32'h40F, 7'd2,  1'b1, 64'h2, 4'd1, 1'b0},
    '{32'h50A, 7'd20, 1'b1, 64'h0000_0000_0005_0001, 4'd2, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_is_load, req_mask_en;
  logic [ADDR_W-1:0] req_addr;
  logic [6:0] req_size;
  logic [MAXB-1:0] req_mask;
  logic frag_valid, frag_ready, frag_is_load, frag_last;
  logic [ADDR_W-1:0] frag_addr;
  logic [4:0] frag_size;
  logic [LINE-1:0] frag_mask;
  logic rsp_valid, done, done_suppressed;

  int n_tests = 0;
  int n_fail  = 0;

  int          e_n;
  logic [31:0] e_addr [8];
  int          e_size [8];
  logic [15:0] e_mask [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  wide_access_splitter #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .MAX_BYTES(MAXB))
  i_wide_access_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_load(req_is_load),
    .req_addr(req_addr), .req_size(req_size), .req_mask_en(req_mask_en),
    .req_mask(req_mask),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_is_load(frag_is_load),
    .frag_addr(frag_addr), .frag_size(frag_size), .frag_mask(frag_mask),
    .frag_last(frag_last), .rsp_valid(rsp_valid),
    .done(done), .done_suppressed(done_suppressed)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte walk: group bytes by line, then drop groups with no enabled byte
  task automatic build_expect(input logic [31:0] addr, input int size,
                              input logic men, input logic [63:0] mask);
    logic [31:0] ra [8];
    int          rs [8];
    logic [15:0] rm [8];
    int nr = 0;
    for (int k = 0; k < size; k++) begin
      logic [31:0] a;
      a = addr + 32'(k);
      if (k == 0 || (a % LINE) == 0) begin
        ra[nr] = a; rs[nr] = 0; rm[nr] = '0; nr++;
      end
      rm[nr-1][rs[nr-1]] = men ? mask[k] : 1'b1;
      rs[nr-1]++;
    end
    e_n = 0;
    for (int f = 0; f < nr; f++) begin
      if (rm[f] != 0) begin
        e_addr[e_n] = ra[f]; e_size[e_n] = rs[f]; e_mask[e_n] = rm[f]; e_n++;
      end
    end
  endtask

  task automatic run_access(input vec_t v, input logic is_load, input logic stall);
    int j = 0, rsp_cnt = 0, it = 0;
    logic pend = 1'b0, held = 1'b0, seen_done = 1'b0;
    logic [31:0] held_addr = '0;
    build_expect(v.addr, int'(v.size), v.men, v.mask);
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_is_load = is_load; req_addr = v.addr;
    req_size = v.size; req_mask_en = v.men; req_mask = v.mask;
    @(negedge clk);
    // keep offering a different request while busy: must be ignored
    req_addr = 32'hDEAD0; req_size = 7'd4; req_mask_en = 1'b0;
    check(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    for (it = 0; it < 60; it++) begin
      rsp_valid = pend; if (pend) rsp_cnt++; pend = 1'b0;
      if (done) begin
        seen_done = 1'b1;
        req_valid = 1'b0; frag_ready = 1'b0; rsp_valid = 1'b0;
        break;
      end
      if (frag_valid) begin
        if (stall && !held) begin
          frag_ready = 1'b0; held = 1'b1; held_addr = frag_addr;
        end else begin
          if (held)
            check(frag_addr == held_addr, "R7 held address", 64'(frag_addr), 64'(held_addr));
          held = 1'b0;
          frag_ready = 1'b1;
          if (j < e_n) begin
            check(frag_addr == e_addr[j], "R3/R5 fragment address", 64'(frag_addr), 64'(e_addr[j]));
            check(int'(frag_size) == e_size[j], "R3 fragment size", 64'(frag_size), 64'(e_size[j]));
            check(frag_mask == e_mask[j], "R4 fragment mask", 64'(frag_mask), 64'(e_mask[j]));
            check(frag_last == (j == e_n - 1), "R6 last flag", 64'(frag_last), 64'(j == e_n - 1));
            check(frag_is_load == is_load, "R3 direction", 64'(frag_is_load), 64'(is_load));
          end else begin
            check(1'b0, "R5 extra fragment", 64'(frag_addr), 64'd0);
          end
          j++; pend = 1'b1;
        end
      end else begin
        frag_ready = 1'b0;
      end
      @(negedge clk);
    end
    check(seen_done, "R8 completion seen", 64'(seen_done), 64'd1);
    check(j == int'(v.nfrag), "R5 fragment count", 64'(j), 64'(v.nfrag));
    check(rsp_cnt == j, "R8 done after all responses", 64'(rsp_cnt), 64'(j));
    check(done_suppressed == v.sup, "R9 suppressed flag", 64'(done_suppressed), 64'(v.sup));
    if (v.sup)
      check(it == 0, "R9 done in cycle after accept", 64'(it), 64'd0);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, "R8 single done pulse, idle again",
          64'({done, req_ready}), 64'b01);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_is_load = 1'b0; req_addr = '0;
    req_size = '0; req_mask_en = 1'b0; req_mask = '0;
    frag_ready = 1'b0; rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    check(frag_valid == 1'b0, "R1 no fragment after reset", 64'(frag_valid), 64'd0);
    check(done == 1'b0 && done_suppressed == 1'b0, "R1 no completion after reset",
          64'({done, done_suppressed}), 64'd0);
    // R8 responses while idle are ignored
    rsp_valid = 1'b1; @(negedge clk); rsp_valid = 1'b0;
    check(done == 1'b0, "R8 idle response ignored", 64'(done), 64'd0);

    for (int i = 0; i < NV; i++) run_access(VECS[i], i[0], i[1]);

    // back-to-back: full-width store, stalling every fragment
    run_access(VECS[2], 1'b0, 1'b1);
    // fully masked right after a normal access
    run_access(VECS[5], 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule